// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block keeps the hidden per-segment state that address generation uses: a 32-bit base, a 32-bit limit and a set of access-rights bits for each of six segment registers (index 0 code, 1 stack, 2 to 5 data). Each time a segment register is written, the matching entry is refreshed, so later memory references read the cached values and never walk a descriptor table.

In real mode a load computes only the base, which is the selector times sixteen. The limit and rights an entry already holds are left as they are. A large limit set up while in protected mode therefore stays in force after the processor returns to real mode. In protected mode the caller supplies the 64-bit descriptor. The block gathers the split base and limit fields, expands the limit by granularity and type-checks the descriptor against the target register. It then either overwrites the whole entry or raises a one-cycle exception with a cause code and leaves the entry untouched. A build parameter selects the older code-segment behaviour, in which a real-mode far transfer restores the code entry's rights and limit to their real-mode defaults.

Top module: `seg_desc_cache`

## Requirements
- R1: After reset every entry has base 0, limit 0x0000FFFF and rights 0x093 (G=0, D/B=0, P=1, DPL=0, S=1, Type=3). The privilege level is 0 and no exception is signalled.
- R2: A real-mode load (prot_mode=0) of segment index n below 6 sets that entry's base to {12'b0, sel, 4'b0} on the next clock. Its limit and rights keep their earlier values, and no exception is raised.
- R3: An accepted protected-mode load replaces the whole entry. The base is {desc[63:56], desc[39:16]}. The rights word is {G=desc[55], D/B=desc[54], P=desc[47], DPL=desc[46:45], S=desc[44], Type=desc[43:40]}, packed into bits 9 down to 0 in that order.
- R4: The 20-bit limit {desc[51:48], desc[15:0]} is stored as {limit20, 12'hFFF} when G=1 and zero-extended when G=0.
- R5: A protected-mode load of the code entry (index 0) needs S=1 and Type bit 3 = 1. Any other descriptor gives cause 2'b01 and leaves the entry unchanged.
- R6: A protected-mode load of indices 1 to 5 needs S=1 and Type bit 3 = 0. Any other descriptor gives cause 2'b01 and leaves the entry unchanged.
- R7: A descriptor that passes the type check but has P=0 gives cause 2'b10 and is not loaded. A type violation has priority over not-present.
- R8: exc_valid is high only in the single cycle after a rejected load. exc_cause is 2'b00 whenever exc_valid is low.
- R9: cpl always equals the DPL field of the stack entry's rights, so it follows every change of that entry.
- R10: With LEGACY_CS=1, a far_xfer pulse in real mode sets the code entry's rights to 0x093 and its limit to 0x0000FFFF and leaves its base alone. If a real-mode code load arrives in the same cycle, its base update still takes effect. far_xfer has no effect in protected mode.
- R11: A load with an index of 6 or 7 changes no entry and raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| ld_valid | input | 1 | Segment register load strobe |
| ld_seg | input | 3 | Index of the segment register being loaded |
| ld_sel | input | 16 | Selector value written |
| ld_desc | input | 64 | Descriptor used by protected-mode loads |
| far_xfer | input | 1 | Far control transfer strobe |
| seg_base | output | 192 | Cached bases, entry i at [32i+31:32i] |
| seg_limit | output | 192 | Cached limits, entry i at [32i+31:32i] |
| seg_attr | output | 60 | Cached rights, entry i at [10i+9:10i] |
| cpl | output | 2 | Current privilege level |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 01 type violation, 10 not present |

## Verification
The properties assume at most one load per clock. They also assume a far transfer arrives only in real mode when it is meant to matter, and that an exception can arise only from a protected-mode load. The stimulus drives one operation per cycle from tasks at the falling edge. Random operations mix both modes and all eight index values. Their descriptors are built from fields, with the executable bit, S and P biased so that accepted loads, type violations and not-present rejections all occur often. Directed cases cover the large real-mode limit surviving a mode switch, the legacy code reset and the cause priority.

// File: rtl/segcache_pkg.sv
package segcache_pkg;
    localparam int SEG_CS = 0;
    localparam int SEG_SS = 1;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic       g;
        logic       db;
        logic       p;
        logic [1:0] dpl;
        logic       s;
        logic [3:0] typ;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    localparam attr_t ATTR_REAL = '{g: 1'b0, db: 1'b0, p: 1'b1, dpl: 2'd0,
                                    s: 1'b1, typ: 4'h3};
    localparam logic [ADDR_W-1:0] LIMIT_REAL = 32'h0000_FFFF;

    typedef enum logic [1:0] {
        EXC_NONE = 2'b00,
        EXC_TYPE = 2'b01,
        EXC_NP   = 2'b10
    } exc_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        attr_t             attr;
    } entry_t;
endpackage

// File: rtl/segcache_unpack.sv
module segcache_unpack
    import segcache_pkg::*;
(
    input  logic [63:0]       desc,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] limit,
    output attr_t             attr
);
    logic [19:0] lim20;

    always_comb begin
        base     = {desc[63:56], desc[39:16]};
        lim20    = {desc[51:48], desc[15:0]};
        attr.g   = desc[55];
        attr.db  = desc[54];
        attr.p   = desc[47];
        attr.dpl = desc[46:45];
        attr.s   = desc[44];
        attr.typ = desc[43:40];
        limit    = attr.g ? {lim20, 12'hFFF} : {12'h000, lim20};
    end
endmodule

// File: rtl/segcache_check.sv
module segcache_check
    import segcache_pkg::*;
(
    input  attr_t attr,
    input  logic  is_code,
    output exc_t  cause
);
    logic exec;
    logic type_ok;

    always_comb begin
        exec    = attr.s && attr.typ[3];
        type_ok = is_code ? exec : (attr.s && !attr.typ[3]);
        if (!type_ok)
            cause = EXC_TYPE;
        else if (!attr.p)
            cause = EXC_NP;
        else
            cause = EXC_NONE;
    end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import segcache_pkg::*;
#(
    parameter int NSEG      = 6,
    parameter bit LEGACY_CS = 1'b1,
    parameter int IDX_W     = 3,
    parameter int SEL_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prot_mode,
    input  logic                     ld_valid,
    input  logic [IDX_W-1:0]         ld_seg,
    input  logic [SEL_W-1:0]         ld_sel,
    input  logic [63:0]              ld_desc,
    input  logic                     far_xfer,
    output logic [NSEG*ADDR_W-1:0]   seg_base,
    output logic [NSEG*ADDR_W-1:0]   seg_limit,
    output logic [NSEG*ATTR_W-1:0]   seg_attr,
    output logic [1:0]               cpl,
    output logic                     exc_valid,
    output logic [1:0]               exc_cause
);
    localparam int PAD_W = ADDR_W - SEL_W - 4;

    typedef struct packed {
        entry_t [NSEG-1:0] ent;
        logic [1:0]        cpl;
        logic              exc_valid;
        exc_t              exc_cause;
    } state_t;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] dsc_base;
    logic [ADDR_W-1:0] dsc_limit;
    attr_t             dsc_attr;
    exc_t              chk_cause;
    logic              is_code;

    assign is_code = (ld_seg == IDX_W'(SEG_CS));

    segcache_unpack u_unpack (
        .desc  (ld_desc),
        .base  (dsc_base),
        .limit (dsc_limit),
        .attr  (dsc_attr)
    );

    segcache_check u_check (
        .attr    (dsc_attr),
        .is_code (is_code),
        .cause   (chk_cause)
    );

    always_comb begin
        st_d           = st_q;
        st_d.exc_valid = 1'b0;
        st_d.exc_cause = EXC_NONE;
        for (int i = 0; i < NSEG; i++) begin
            if (ld_valid && ld_seg == IDX_W'(i)) begin
                if (!prot_mode) begin
                    st_d.ent[i].base = {{PAD_W{1'b0}}, ld_sel, 4'b0000};
                end else if (chk_cause != EXC_NONE) begin
                    st_d.exc_valid = 1'b1;
                    st_d.exc_cause = chk_cause;
                end else begin
                    st_d.ent[i].base  = dsc_base;
                    st_d.ent[i].limit = dsc_limit;
                    st_d.ent[i].attr  = dsc_attr;
                end
            end
        end
        if (LEGACY_CS && far_xfer && !prot_mode) begin
            st_d.ent[SEG_CS].attr  = ATTR_REAL;
            st_d.ent[SEG_CS].limit = LIMIT_REAL;
        end
        st_d.cpl = st_d.ent[SEG_SS].attr.dpl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                st_q.ent[i].base  <= '0;
                st_q.ent[i].limit <= LIMIT_REAL;
                st_q.ent[i].attr  <= ATTR_REAL;
            end
            st_q.cpl       <= 2'd0;
            st_q.exc_valid <= 1'b0;
            st_q.exc_cause <= EXC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_out
        assign seg_base[g*ADDR_W +: ADDR_W]  = st_q.ent[g].base;
        assign seg_limit[g*ADDR_W +: ADDR_W] = st_q.ent[g].limit;
        assign seg_attr[g*ATTR_W +: ATTR_W]  = st_q.ent[g].attr;
    end

    assign cpl       = st_q.cpl;
    assign exc_valid = st_q.exc_valid;
    assign exc_cause = st_q.exc_cause;
endmodule

// File: rtl/seg_desc_cache_chk.sv
module seg_desc_cache_chk
    import segcache_pkg::*;
#(
    parameter int NSEG      = 6,
    parameter bit LEGACY_CS = 1'b1,
    parameter int IDX_W     = 3,
    parameter int SEL_W     = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   prot_mode,
    input logic                   ld_valid,
    input logic [IDX_W-1:0]       ld_seg,
    input logic [SEL_W-1:0]       ld_sel,
    input logic [63:0]            ld_desc,
    input logic                   far_xfer,
    input logic [NSEG*ADDR_W-1:0] seg_base,
    input logic [NSEG*ADDR_W-1:0] seg_limit,
    input logic [NSEG*ATTR_W-1:0] seg_attr,
    input logic [1:0]             cpl,
    input logic                   exc_valid,
    input logic [1:0]             exc_cause
);
    localparam int PAD_W = ADDR_W - SEL_W - 4;

    AST_EXC_FROM_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(prot_mode && ld_valid)); // R8
    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> exc_cause == 2'b00); // R8
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause == 2'b01 || exc_cause == 2'b10)); // R8
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($stable(seg_base) && $stable(seg_limit) && $stable(seg_attr))); // R5
    AST_CPL_FROM_SS: assert property (@(posedge clk) disable iff (!rst_n)
        cpl == seg_attr[SEG_SS*ATTR_W+5 +: 2]); // R9
    AST_BAD_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && int'(ld_seg) >= NSEG && !far_xfer) |=>
        ($stable(seg_base) && $stable(seg_limit) && $stable(seg_attr) && !exc_valid)); // R11

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        AST_REAL_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_valid && !prot_mode && ld_seg == IDX_W'(g)) |=>
            seg_base[g*ADDR_W +: ADDR_W] == {{PAD_W{1'b0}}, $past(ld_sel), 4'b0000}); // R2
        AST_REAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_valid && !prot_mode && ld_seg == IDX_W'(g) && !(g == SEG_CS && far_xfer)) |=>
            ($stable(seg_limit[g*ADDR_W +: ADDR_W]) && $stable(seg_attr[g*ATTR_W +: ATTR_W]))); // R2
    end
endmodule

bind seg_desc_cache seg_desc_cache_chk #(
    .NSEG(NSEG), .LEGACY_CS(LEGACY_CS), .IDX_W(IDX_W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/sim_seg_desc_cache.sv
`timescale 1ns/1ps
module sim_seg_desc_cache;
    localparam int NSEG = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prot_mode = 1'b0;
    logic              ld_valid = 1'b0;
    logic [2:0]        ld_seg = '0;
    logic [15:0]       ld_sel = '0;
    logic [63:0]       ld_desc = '0;
    logic              far_xfer = 1'b0;
    logic [NSEG*32-1:0] seg_base;
    logic [NSEG*32-1:0] seg_limit;
    logic [NSEG*10-1:0] seg_attr;
    logic [1:0]        cpl;
    logic              exc_valid;
    logic [1:0]        exc_cause;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_base [NSEG];
    logic [31:0] m_lim  [NSEG];
    logic [9:0]  m_attr [NSEG];
    logic        m_exc;
    logic [1:0]  m_cause;

    always #2 clk = ~clk;

    seg_desc_cache u0 (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .ld_valid(ld_valid),
        .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_desc(ld_desc), .far_xfer(far_xfer),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_attr(seg_attr),
        .cpl(cpl), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    function automatic logic [63:0] mk_desc(logic [31:0] b, logic [19:0] l, logic g,
                                            logic db, logic p, logic [1:0] dpl,
                                            logic s, logic [3:0] t);
        return {b[31:24], g, db, 1'b0, 1'b0, l[19:16], p, dpl, s, t, b[23:0], l[15:0]};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int i = 0; i < NSEG; i++) begin
            chk(tag, 64'(seg_base[i*32 +: 32]), 64'(m_base[i]));
            chk(tag, 64'(seg_limit[i*32 +: 32]), 64'(m_lim[i]));
            chk(tag, 64'(seg_attr[i*10 +: 10]), 64'(m_attr[i]));
        end
        chk({tag, " R9 cpl"}, 64'(cpl), 64'(m_attr[1][6:5]));
        chk({tag, " R8 exc"}, 64'({exc_valid, exc_cause}), 64'({m_exc, m_cause}));
    endtask

    task automatic model(logic pm, logic lv, logic [2:0] sg, logic [15:0] sel,
                         logic [63:0] d, logic fx);
        logic [9:0]  a;
        logic [19:0] l20;
        logic        ok;
        m_exc   = 1'b0;
        m_cause = 2'b00;
        if (lv && sg < 3'd6) begin
            if (!pm) begin
                m_base[sg] = {12'b0, sel, 4'b0};
            end else begin
                a   = {d[55], d[54], d[47], d[46:45], d[44], d[43:40]};
                l20 = {d[51:48], d[15:0]};
                ok  = (sg == 3'd0) ? (a[4] && a[3]) : (a[4] && !a[3]);
                if (!ok) begin
                    m_exc = 1'b1; m_cause = 2'b01;
                end else if (!a[7]) begin
                    m_exc = 1'b1; m_cause = 2'b10;
                end else begin
                    m_base[sg] = {d[63:56], d[39:16]};
                    m_lim[sg]  = a[9] ? {l20, 12'hFFF} : {12'h000, l20};
                    m_attr[sg] = a;
                end
            end
        end
        if (fx && !pm) begin
            m_attr[0] = 10'h093;
            m_lim[0]  = 32'h0000_FFFF;
        end
    endtask

    task automatic step(string tag, logic pm, logic lv, logic [2:0] sg,
                        logic [15:0] sel, logic [63:0] d, logic fx);
        @(negedge clk);
        prot_mode = pm; ld_valid = lv; ld_seg = sg; ld_sel = sel;
        ld_desc = d; far_xfer = fx;
        @(posedge clk);
        model(pm, lv, sg, sel, d, fx);
        #1;
        compare_all(tag);
        ld_valid = 1'b0; far_xfer = 1'b0;
    endtask

    task automatic idle(string tag);
        step(tag, prot_mode, 1'b0, 3'd0, 16'h0, 64'h0, 1'b0);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rb;
        logic [19:0] rl;
        logic [3:0]  rt;
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = '0; m_lim[i] = 32'h0000_FFFF; m_attr[i] = 10'h093;
        end
        m_exc = 1'b0; m_cause = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1 reset");

        step("R2 real DS", 1'b0, 1'b1, 3'd2, 16'hB800, 64'h0, 1'b0);
        step("R3 prot DS g0", 1'b1, 1'b1, 3'd2, 16'h10,
             mk_desc(32'h1234_5678, 20'hABCDE, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 4'h2), 1'b0);
        step("R4 prot ES g1", 1'b1, 1'b1, 3'd3, 16'h18,
             mk_desc(32'h0, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 4'h3), 1'b0);
        step("R2 unreal ES kept", 1'b0, 1'b1, 3'd3, 16'h2000, 64'h0, 1'b0);
        step("R5 CS data desc", 1'b1, 1'b1, 3'd0, 16'h8,
             mk_desc(32'h5000, 20'h1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'h3), 1'b0);
        idle("R8 pulse ends");
        step("R6 SS exec desc", 1'b1, 1'b1, 3'd1, 16'h8,
             mk_desc(32'h5000, 20'h1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'hA), 1'b0);
        step("R6 FS system desc", 1'b1, 1'b1, 3'd4, 16'h8,
             mk_desc(32'h5000, 20'h1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'h2), 1'b0);
        step("R7 GS not present", 1'b1, 1'b1, 3'd5, 16'h8,
             mk_desc(32'h5000, 20'h1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'h2), 1'b0);
        step("R7 priority type", 1'b1, 1'b1, 3'd0, 16'h8,
             mk_desc(32'h5000, 20'h1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'h2), 1'b0);
        step("R9 SS dpl3", 1'b1, 1'b1, 3'd1, 16'h23,
             mk_desc(32'h7000, 20'h00FFF, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 4'h2), 1'b0);
        step("R3 prot CS code", 1'b1, 1'b1, 3'd0, 16'h8,
             mk_desc(32'hFF00_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 4'hB), 1'b0);
        step("R10 far in prot ignored", 1'b1, 1'b0, 3'd0, 16'h0, 64'h0, 1'b1);
        step("R10 real far resets CS", 1'b0, 1'b0, 3'd0, 16'h0, 64'h0, 1'b1);
        step("R10 far with CS load", 1'b0, 1'b1, 3'd0, 16'hF000, 64'h0, 1'b1);
        step("R11 index 6", 1'b1, 1'b1, 3'd6, 16'h8,
             mk_desc(32'h5000, 20'h1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'h2), 1'b0);
        step("R11 index 7", 1'b0, 1'b1, 3'd7, 16'h1234, 64'h0, 1'b0);

        void'($urandom(32'd2024));
        for (int n = 0; n < 600; n++) begin
            rb = $urandom;
            rl = 20'($urandom);
            rt = 4'($urandom);
            step("R3 R4 R5 R6 R7 random", 1'($urandom), ($urandom % 4) != 0,
                 3'($urandom), 16'($urandom),
                 mk_desc(rb, rl, 1'($urandom), 1'($urandom), ($urandom % 5) != 0,
                         2'($urandom), ($urandom % 6) != 0, rt),
                 ($urandom % 8) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule